// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block produces the 12-bit address of the next microinstruction on every cycle. The control store supplies a 2-bit next-address code, and a four-way multiplexer picks one of four sources: the sequential address, a branch address, an alternate address that acts as a subroutine call, or the top of an eight-entry return-address stack that acts as a return. The multiplexer output is combinational. It is also fed back through a ripple incrementer into a program-counter register, so the sequential source always holds the last selected address plus one.

A call writes the program-counter register into the stack. The write enable is decoded from the select code alone: high bit 1, low bit 0. The write data is taken from a copy of the program-counter register that is captured on the falling clock edge, so it cannot change while the write completes. Two separate controls, push and pop, move the 3-bit stack pointer. It wraps modulo 8, so overflow and underflow are defined.

Top module: `useq_nextaddr`

## Requirements
- R1: A synchronous reset clears the program-counter register to 0x000 and the stack pointer to 0. With code 00 in the first cycle after reset, the output is 0x000.
- R2: Code 00 selects the program-counter register, which holds the previous cycle's output plus one.
- R3: Code 01 outputs the branch address input.
- R4: Code 10 outputs the alternate address input and writes the program-counter register into the stack word at the current stack pointer.
- R5: Code 11 outputs the stack word at index (stack pointer − 1) modulo 8.
- R6: At a clock edge, push alone adds one to the stack pointer after the write, and pop alone subtracts one. When push and pop are both high, or both low, the pointer holds.
- R7: The stack pointer wraps modulo 8. A ninth push overwrites word 0, and a pop from pointer 0 reads word 7.
- R8: The stack is written only under code 10. A push under any other code moves the pointer but leaves the stack contents unchanged.
- R9: The incrementer wraps from 0xFFF to 0x000. Its final carry is dropped.
- R10: The stack write data is a falling-edge copy of the program-counter register. At each rising edge it equals that register, so a call followed by a return yields the value the register held during the call.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| nsel | input | 2 | Next-address code: 00 sequential, 01 branch, 10 call, 11 return |
| br_addr | input | 12 | Branch target |
| alt_addr | input | 12 | Call target |
| sp_push | input | 1 | Increment the stack pointer at this edge |
| sp_pop | input | 1 | Decrement the stack pointer at this edge |
| next_addr | output | 12 | Selected next microinstruction address |

## Verification
The assertions check four things on every cycle:
- the plus-one step of the sequential path, including its wrap, and the zero address after reset;
- that the stack pointer holds when push and pop agree;
- that the falling-edge write-data copy matches the program-counter register at each rising edge;
- that a return directly after a pushing call gives back the register value from the call.

Other behaviours can only be shown by the bench's scenarios, because they depend on the history of the stack contents:
- the branch and call sources;
- nested calls and returns;
- pointer wrap on overflow and underflow;
- the absence of a write when a push happens under a code other than call;
- reset in the middle of a run.

// File: rtl/useq_nextaddr.sv
module useq_nextaddr #(
  parameter int AW    = 12,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    nsel,
  input  logic [AW-1:0] br_addr,
  input  logic [AW-1:0] alt_addr,
  input  logic          sp_push,
  input  logic          sp_pop,
  output logic [AW-1:0] next_addr
);
  localparam int SPW = $clog2(DEPTH);

  logic [AW-1:0]  pc_q, wd_q, inc, tos;
  logic [AW-1:0]  cy;
  logic [AW-1:0]  stk [DEPTH];
  logic [SPW-1:0] sp, sp_dn;
  logic           wr_en;

  assign cy[0] = 1'b1;
  for (genvar i = 0; i < AW; i++) begin : g_inc
    assign inc[i] = next_addr[i] ^ cy[i];
    if (i < AW-1) begin : g_cy
      assign cy[i+1] = next_addr[i] & cy[i];
    end
  end

  assign wr_en = ~(~nsel[1] | nsel[0]);
  assign sp_dn = sp - 1'b1;
  assign tos   = stk[sp_dn];

  always_comb begin
    case (nsel)
      2'b00:   next_addr = pc_q;
      2'b01:   next_addr = br_addr;
      2'b10:   next_addr = alt_addr;
      default: next_addr = tos;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= '0;
      sp   <= '0;
    end else begin
      pc_q <= inc;
      case ({sp_push, sp_pop})
        2'b10:   sp <= sp + 1'b1;
        2'b01:   sp <= sp_dn;
        default: sp <= sp;
      endcase
    end
  end

  always_ff @(negedge clk) wd_q <= pc_q;

  always_ff @(posedge clk) begin
    if (wr_en) stk[sp] <= wd_q;
  end
endmodule

module useq_nextaddr_chk #(
  parameter int AW  = 12,
  parameter int SPW = 3
) (
  input logic           clk,
  input logic           rst,
  input logic [1:0]     nsel,
  input logic           sp_push,
  input logic           sp_pop,
  input logic [AW-1:0]  next_addr,
  input logic [AW-1:0]  pc_q,
  input logic [AW-1:0]  wd_q,
  input logic [SPW-1:0] sp
);
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && nsel == 2'b00) |-> next_addr == '0);

  // also covers R9: the compare is AW bits wide, so 0xFFF steps to 0x000
  p_seq_step_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && nsel == 2'b00) |-> next_addr == $past(next_addr) + 1'b1);

  p_call_ret_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(nsel == 2'b10 && sp_push && !sp_pop) && nsel == 2'b11)
    |-> next_addr == $past(pc_q));

  p_sp_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sp_push) == $past(sp_pop)) |-> sp == $past(sp));

  p_wdata_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> wd_q == pc_q);
endmodule

bind useq_nextaddr useq_nextaddr_chk #(.AW(AW), .SPW(SPW)) u_chk (
  .clk(clk), .rst(rst), .nsel(nsel), .sp_push(sp_push), .sp_pop(sp_pop),
  .next_addr(next_addr), .pc_q(pc_q), .wd_q(wd_q), .sp(sp)
);

// File: tb/sim_useq_nextaddr.sv
`timescale 1ns/1ps
module sim_useq_nextaddr;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  nsel = 2'b00;
  logic [11:0] br_addr = '0, alt_addr = '0;
  logic        sp_push = 1'b0, sp_pop = 1'b0;
  logic [11:0] next_addr;
  int          n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  useq_nextaddr u0 (.clk(clk), .rst(rst), .nsel(nsel), .br_addr(br_addr),
    .alt_addr(alt_addr), .sp_push(sp_push), .sp_pop(sp_pop), .next_addr(next_addr));

  // {nsel, push, pop, branch, alternate, expected}
  localparam logic [39:0] VEC [13] = '{
    {2'b00, 1'b0, 1'b0, 12'h000, 12'h000, 12'h000},
    {2'b00, 1'b0, 1'b0, 12'h000, 12'h000, 12'h001},
    {2'b01, 1'b0, 1'b0, 12'h100, 12'h000, 12'h100},
    {2'b00, 1'b0, 1'b0, 12'h000, 12'h000, 12'h101},
    {2'b10, 1'b1, 1'b0, 12'h000, 12'h200, 12'h200},
    {2'b00, 1'b0, 1'b0, 12'h000, 12'h000, 12'h201},
    {2'b10, 1'b1, 1'b0, 12'h000, 12'h300, 12'h300},
    {2'b11, 1'b0, 1'b1, 12'h000, 12'h000, 12'h202},
    {2'b00, 1'b0, 1'b0, 12'h000, 12'h000, 12'h203},
    {2'b11, 1'b0, 1'b1, 12'h000, 12'h000, 12'h102},
    {2'b00, 1'b0, 1'b0, 12'h000, 12'h000, 12'h103},
    {2'b01, 1'b0, 1'b0, 12'hFFF, 12'h000, 12'hFFF},
    {2'b00, 1'b0, 1'b0, 12'h000, 12'h000, 12'h000}
  };

  task automatic chk(input string tag, input logic [11:0] got, input logic [11:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: next_addr=%h expected %h", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; nsel = 2'b00; sp_push = 1'b0; sp_pop = 1'b0;
    @(posedge clk); #1 rst = 1'b0;
  endtask

  task automatic step(input logic [1:0] s, input logic pu, input logic po,
                      input logic [11:0] br, input logic [11:0] alt,
                      input logic [11:0] exp, input string tag);
    nsel = s; sp_push = pu; sp_pop = po; br_addr = br; alt_addr = alt;
    #1 chk(tag, next_addr, exp);
    @(posedge clk); #1;
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    @(posedge clk); #1;
    do_reset();
    for (int i = 0; i < 13; i++) begin
      string tag;
      case (VEC[i][39:38])
        2'b00:   tag = (i == 0) ? "R1 reset" : (i == 12) ? "R9 wrap" : "R2 sequential";
        2'b01:   tag = "R3 branch";
        2'b10:   tag = "R4 call";
        default: tag = "R5/R10 return";
      endcase
      step(VEC[i][39:38], VEC[i][37], VEC[i][36], VEC[i][35:24], VEC[i][23:12],
           VEC[i][11:0], tag);
    end

    // R7: overflow and underflow wrap
    do_reset();
    for (int i = 0; i < 9; i++)
      step(2'b10, 1'b1, 1'b0, 12'h0, 12'h400 + 12'(i * 16), 12'h400 + 12'(i * 16), "R4 call");
    step(2'b11, 1'b0, 1'b1, 12'h0, 12'h0, 12'h471, "R7 overflow overwrite");
    step(2'b11, 1'b0, 1'b1, 12'h0, 12'h0, 12'h461, "R7 underflow wrap");

    // R8: a push under a code other than call does not write
    do_reset();
    step(2'b10, 1'b1, 1'b0, 12'h0, 12'h500, 12'h500, "R4 call");
    step(2'b10, 1'b1, 1'b0, 12'h0, 12'h600, 12'h600, "R4 call");
    step(2'b11, 1'b0, 1'b1, 12'h0, 12'h0, 12'h501, "R5 return");
    step(2'b00, 1'b1, 1'b0, 12'h0, 12'h0, 12'h502, "R2 sequential");
    step(2'b11, 1'b0, 1'b1, 12'h0, 12'h0, 12'h501, "R8 no write");

    // R6: push and pop together hold the pointer
    do_reset();
    step(2'b10, 1'b1, 1'b0, 12'h0, 12'h700, 12'h700, "R4 call");
    step(2'b00, 1'b1, 1'b1, 12'h0, 12'h0, 12'h701, "R2 sequential");
    step(2'b11, 1'b0, 1'b1, 12'h0, 12'h0, 12'h000, "R6 push+pop hold");

    // R1: reset in the middle of a run
    step(2'b01, 1'b0, 1'b0, 12'h3A0, 12'h0, 12'h3A0, "R3 branch");
    do_reset();
    step(2'b00, 1'b0, 1'b0, 12'h0, 12'h0, 12'h000, "R1 mid-run reset");
    step(2'b00, 1'b0, 1'b0, 12'h0, 12'h0, 12'h001, "R2 sequential");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule